// File: doc/BRIEF.md
# Single-Car Elevator Controller with Runtime Floor Count

This block steers one elevator car between floors. It is a state machine with two kinds of state: the car is either standing with its door open at a floor, or travelling toward a target floor with the door shut. Floor buttons inside the car and hall call buttons on each landing are latched as pending requests. Each floor has a position sensor, and the controller uses these sensors to decide when the car has arrived.

The hardware is built for a maximum number of floors `NF`. A configuration register holds the number of floors actually in service. While the `cfg_load` input is high, that register takes the value on `cfg_floors`. Buttons and sensors for floors at or above the configured count are ignored. Floors are numbered from zero: index 0 is the ground floor.

Pending requests are served in a sweep. The car keeps moving in its current direction and stops at the nearest pending floor in that direction. It turns around only when no request remains ahead of it. After reset the direction is upward, so requests above the car are served before any below it. Motor drive, door timing and fault handling are handled elsewhere.

Top module: `lift_car_ctrl`

## Requirements
- R1: After reset the car is open at index 0 (`state_moving`=0, `state_floor`=0, `door_open`=1). No request is pending and the configured floor count is zero, so every button press is ignored until a count is loaded.
- R2: While `cfg_load` is high, the count takes `cfg_floors`, saturated to `NF`. A car button, hall button or sensor at an index at or above the count has no effect. A hall-up button at index count-1 has no effect. A hall-down button at index 0 has no effect.
- R3: A press is sampled on one rising clock edge and latched on that edge. If the car is open, it enters the moving state toward its chosen target on the next edge, and `state_floor` shows the target index.
- R4: A moving car goes to the open state at its target on the first clock edge at which that floor's sensor reads 1 after having read 0 on the previous edge. Sensors of other floors have no effect. A sensor that was already 1 when the car started moving has no effect until it falls and rises again.
- R5: `door_open` is 0 in every moving state and 1 in every open state.
- R6: A press of any button for the floor where the car stands open is ignored, and the car stays open.
- R7: When the car's direction is upward, every pending request above the car is served before any request below it.
- R8: When the car moves upward, the target is the nearest floor above with a car or hall-up request. If no such floor exists, the target is the highest floor above with a hall-down request. Moving downward mirrors this: the nearest floor below with a car or hall-down request, or else the lowest floor below with a hall-up request.
- R9: The direction is reversed only when no request is pending ahead of the car. A car travelling downward keeps going down past pending requests above it.
- R10: With no request pending, the car stays open at its current floor. Arrival at a floor clears every request type latched for that floor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load the active floor count |
| cfg_floors | input | CW | Active floor count to load |
| car_btn | input | NF | In-car floor buttons, one per floor index |
| hall_up | input | NF | Hall up-call buttons |
| hall_dn | input | NF | Hall down-call buttons |
| floor_sense | input | NF | Per-floor position sensors |
| state_moving | output | 1 | 1 when travelling, 0 when standing open |
| state_floor | output | FW | Target floor while moving, current floor while open |
| door_open | output | 1 | Door open flag |

## Verification
Four properties are checked on every cycle:
- An open state is entered only from a moving state whose target sensor reads high.
- The target floor does not change during travel.
- Starting to move always names a new floor.
- The floor does not change while the car stands open.

Only the directed scenarios can show the request-ordering rules: up-first service, nearest-stop choice, the hall-down fallback and the reversal point. The same holds for masking by the configured floor count and for the rule that a held sensor does not count as an arrival. These rules depend on the history of presses, which the assertions do not model.

// File: rtl/lift_car_ctrl.sv
module lift_car_ctrl #(
  parameter int NF = 8,
  localparam int FW = $clog2(NF),
  localparam int CW = $clog2(NF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_floors,
  input  logic [NF-1:0] car_btn,
  input  logic [NF-1:0] hall_up,
  input  logic [NF-1:0] hall_dn,
  input  logic [NF-1:0] floor_sense,
  output logic          state_moving,
  output logic [FW-1:0] state_floor,
  output logic          door_open
);

  logic [CW-1:0] cnt_q;
  logic [NF-1:0] act, up_ok, dn_ok, ab, bl;
  logic [NF-1:0] car_r, up_r, dn_r, sense_d;
  logic [NF-1:0] here, open_here, rise, clr, pend;
  logic          moving, dir_up, arrive, any_ab, any_bl, go_up, go_dn, hit;
  logic [FW-1:0] floor_q, tgt;

  for (genvar i = 0; i < NF; i++) begin : g_mask
    assign act[i]   = CW'(i) < cnt_q;
    assign up_ok[i] = CW'(i + 1) < cnt_q;
    if (i == 0) begin : g_bot
      assign dn_ok[i] = 1'b0;
    end else begin : g_mid
      assign dn_ok[i] = act[i];
    end
    assign ab[i] = FW'(i) > floor_q;
    assign bl[i] = FW'(i) < floor_q;
  end

  assign here      = {{(NF-1){1'b0}}, 1'b1} << floor_q;
  assign open_here = moving ? '0 : here;
  assign rise      = floor_sense & ~sense_d & act;
  assign arrive    = moving && rise[floor_q];
  assign clr       = arrive ? here : '0;
  assign pend      = car_r | up_r | dn_r;
  assign any_ab    = |(pend & ab);
  assign any_bl    = |(pend & bl);
  assign go_up     = any_ab && (dir_up || !any_bl);
  assign go_dn     = any_bl && !go_up;

  always_comb begin
    tgt = floor_q;
    hit = 1'b0;
    if (go_up) begin
      for (int i = NF - 1; i >= 0; i--)
        if (ab[i] && (car_r[i] || up_r[i])) begin tgt = FW'(i); hit = 1'b1; end
      if (!hit)
        for (int i = 0; i < NF; i++)
          if (ab[i] && dn_r[i]) tgt = FW'(i);
    end else if (go_dn) begin
      for (int i = 0; i < NF; i++)
        if (bl[i] && (car_r[i] || dn_r[i])) begin tgt = FW'(i); hit = 1'b1; end
      if (!hit)
        for (int i = NF - 1; i >= 0; i--)
          if (bl[i] && up_r[i]) tgt = FW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      car_r   <= '0;
      up_r    <= '0;
      dn_r    <= '0;
      sense_d <= '0;
      moving  <= 1'b0;
      floor_q <= '0;
      dir_up  <= 1'b1;
    end else begin
      if (cfg_load) cnt_q <= (cfg_floors > CW'(NF)) ? CW'(NF) : cfg_floors;
      sense_d <= floor_sense;
      car_r   <= (car_r | (car_btn & ~open_here)) & act & ~clr;
      up_r    <= (up_r | (hall_up & ~open_here)) & up_ok & ~clr;
      dn_r    <= (dn_r | (hall_dn & ~open_here)) & dn_ok & ~clr;
      if (moving) begin
        if (arrive) moving <= 1'b0;
      end else if (go_up || go_dn) begin
        moving  <= 1'b1;
        floor_q <= tgt;
        dir_up  <= go_up;
      end
    end
  end

  assign state_moving = moving;
  assign state_floor  = floor_q;
  assign door_open    = !moving;

endmodule

// File: rtl/lift_car_ctrl_chk.sv
module lift_car_ctrl_chk #(
  parameter int NF = 8,
  localparam int FW = $clog2(NF)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          state_moving,
  input logic [FW-1:0] state_floor,
  input logic [NF-1:0] floor_sense
);

  // R4
  open_needs_sensor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!state_moving && $past(state_moving)) |-> $past(floor_sense[state_floor]));

  // R3
  target_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_moving && $past(state_moving)) |-> $stable(state_floor));

  // R6
  depart_new_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_moving) |-> (state_floor != $past(state_floor)));

  // R10
  open_floor_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!state_moving && $past(!state_moving)) |-> $stable(state_floor));

endmodule

bind lift_car_ctrl lift_car_ctrl_chk #(.NF(NF)) chk_i (
  .clk(clk), .rst_n(rst_n), .state_moving(state_moving),
  .state_floor(state_floor), .floor_sense(floor_sense));

// File: tb/lift_car_ctrl_test.sv
module lift_car_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int NF = 8;

  logic clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0;
  logic [3:0] cfg_floors = '0;
  logic [NF-1:0] car_btn = '0, hall_up = '0, hall_dn = '0, floor_sense = '0;
  logic state_moving, door_open;
  logic [2:0] state_floor;
  int n_run = 0, n_fail = 0;

  lift_car_ctrl #(.NF(NF)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_floors(cfg_floors),
    .car_btn(car_btn), .hall_up(hall_up), .hall_dn(hall_dn),
    .floor_sense(floor_sense), .state_moving(state_moving),
    .state_floor(state_floor), .door_open(door_open));

  always #(CLK_NS/2) clk = ~clk;

  initial begin
    #(200000 * CLK_NS);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag, int mv, int fl);
    chk({tag, " moving"}, int'(state_moving), mv);
    chk({tag, " floor"}, int'(state_floor), fl);
    chk({tag, " door"}, int'(door_open), 1 - mv);
  endtask

  task automatic press(logic [NF-1:0] c, logic [NF-1:0] u, logic [NF-1:0] d);
    car_btn = c; hall_up = u; hall_dn = d;
    tick();
    car_btn = '0; hall_up = '0; hall_dn = '0;
    tick();
  endtask

  task automatic arrive(int k);
    floor_sense[k] = 1'b1;
    tick();
    chk_state("R4 arrival", 0, k);
    floor_sense[k] = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk_state("R1 reset", 0, 0);
    press(8'h08, '0, '0);
    chk_state("R1 R2 zero count", 0, 0);
  endtask

  task automatic t_config_move();
    cfg_floors = 4'd5; cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
    press(8'h04, '0, '0);
    chk_state("R3 R5 depart", 1, 2);
    floor_sense[1] = 1'b1;
    tick();
    floor_sense[1] = 1'b0;
    chk_state("R4 other sensor", 1, 2);
    arrive(2);
    tick(); tick();
    chk_state("R10 idle", 0, 2);
  endtask

  task automatic t_ignore();
    press(8'h04, 8'h04, 8'h04);
    chk_state("R6 same floor", 0, 2);
    press(8'h40, '0, '0);
    chk_state("R2 above count", 0, 2);
    press('0, 8'h10, '0);
    chk_state("R2 top hall up", 0, 2);
  endtask

  task automatic t_up_first();
    press(8'h11, 8'h08, '0);
    chk_state("R7 R8 nearest up", 1, 3);
    arrive(3);
    tick();
    chk_state("R7 continue up", 1, 4);
    arrive(4);
    tick();
    chk_state("R9 reverse", 1, 0);
    arrive(0);
  endtask

  task automatic t_hall_dn_above();
    press('0, '0, 8'h0C);
    chk_state("R8 highest down call", 1, 3);
    arrive(3);
    tick();
    chk_state("R8 then down", 1, 2);
    arrive(2);
  endtask

  task automatic t_hold_down();
    press(8'h11, '0, '0);
    chk_state("R9 keep down", 1, 0);
    arrive(0);
    tick();
    chk_state("R9 then up", 1, 4);
    arrive(4);
    tick();
    chk_state("R10 cleared", 0, 4);
  endtask

  task automatic t_held_sensor();
    floor_sense[1] = 1'b1;
    press(8'h02, '0, '0);
    chk_state("R4 held sensor start", 1, 1);
    tick(); tick();
    chk_state("R4 held sensor no stop", 1, 1);
    floor_sense[1] = 1'b0;
    tick();
    arrive(1);
  endtask

  task automatic t_reset_again();
    do_reset();
    chk_state("R1 re-reset", 0, 0);
    press(8'h02, '0, '0);
    chk_state("R1 count cleared", 0, 0);
  endtask

  initial begin
    t_reset();
    t_config_move();
    t_ignore();
    t_up_first();
    t_hall_dn_above();
    t_hold_down();
    t_held_sensor();
    t_reset_again();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule